// File: doc/BRIEF.md
# Local Reset Generator for a Gated Clock Domain

This block supplies resets to logic that runs on a locally generated or gated clock. That clock may start well after the system clock, or it may stop at any time. A global reset arrives in the system clock domain. The block stretches it with a counter into a clock-generator reset, which is released on the system clock. It then carries that release into the local domain through a shift-register synchronizer, which produces the register reset. The register reset is therefore released only after the local clock has ticked several times.

A toggle flop in the local domain proves that the local clock is alive. Its state is synchronized back into the system domain, where a counter watches it. Each observed toggle clears the counter. If the counter reaches its limit while the clock-generator reset is released, the block treats the local clock as dead. It then reasserts the clock-generator reset for a full hold period, and the register reset follows at once. Both resets are asserted asynchronously. Each is released synchronously to its own clock.

Top module: `lrst_gen`

## Requirements
- R1: While `sys_rst` is high, both `clkgen_rst` and `reg_rst` are high. They rise without waiting for any clock edge when `sys_rst` rises between edges.
- R2: `clkgen_rst` goes low at exactly the HOLD_CYCLES-th rising edge of `sys_clk` after the event that started the hold. That event is either the release of `sys_rst` or a watchdog reassertion.
- R3: Whenever `clkgen_rst` is high, `reg_rst` is also high. This holds even when the local clock is not toggling.
- R4: After `clkgen_rst` goes low, `reg_rst` goes low at exactly the SYNC_STAGES-th rising edge of `loc_clk`.
- R5: If `loc_clk` is stopped, `clkgen_rst` rises again exactly TIMEOUT_CYCLES rising edges of `sys_clk` after it was released. The hold/timeout cycle then repeats for as long as the clock stays dead. The first detection after the clock stops comes no sooner than TIMEOUT_CYCLES cycles.
- R6: While `loc_clk` runs with a period well below TIMEOUT_CYCLES system clock periods, `clkgen_rst` and `reg_rst` stay low once released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Global reset, active high, asynchronous assert |
| loc_clk | input | 1 | Local (gated or generated) clock being supervised |
| clkgen_rst | output | 1 | Reset for the local clock generator, released on `sys_clk` |
| reg_rst | output | 1 | Reset for registers on `loc_clk`, released on `loc_clk` |

## Verification
The hardest situation to reach is a dead local clock that is caught while the clock-generator reset is released. Only then does the watchdog window run, and its exact length is observable only once stale toggles have drained from the synchronizer. The bench gates its own local clock source to freeze it. It then measures the low time of `clkgen_rst` over several consecutive hold/timeout rounds after the first detection, and checks that `reg_rst` never drops without local edges. Finally it revives the clock while `clkgen_rst` is asserted, so that the next release counts local edges cleanly. The release sequence is swept over a range of local clock periods, both faster and slower than the system clock.

// File: rtl/lrst_gen.sv
module lrst_gen #(
  parameter int HOLD_CYCLES    = 16,
  parameter int SYNC_STAGES    = 3,
  parameter int TIMEOUT_CYCLES = 256
) (
  input  logic sys_clk,
  input  logic sys_rst,
  input  logic loc_clk,
  output logic clkgen_rst,
  output logic reg_rst
);
  localparam int HW = $clog2(HOLD_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

  logic [HW-1:0]          hold_cnt;
  logic                   hold_q;
  logic [TW-1:0]          wd_cnt;
  logic                   wd_fire;
  logic                   tog_loc;
  logic [SYNC_STAGES-1:0] tog_sync;
  logic                   tog_prev;
  logic                   tog_seen;
  logic [SYNC_STAGES-1:0] rst_pipe;

  assign tog_seen   = tog_sync[SYNC_STAGES-1] ^ tog_prev;
  assign wd_fire    = !hold_q && !tog_seen && (wd_cnt == TW'(TIMEOUT_CYCLES - 1));
  assign clkgen_rst = hold_q;
  assign reg_rst    = rst_pipe[SYNC_STAGES-1];

  always_ff @(posedge sys_clk or posedge sys_rst)
    if (sys_rst) begin
      hold_cnt <= '0;
      hold_q   <= 1'b1;
    end else if (wd_fire) begin
      hold_cnt <= '0;
      hold_q   <= 1'b1;
    end else if (hold_q) begin
      hold_cnt <= hold_cnt + HW'(1);
      hold_q   <= (hold_cnt != HW'(HOLD_CYCLES - 1));
    end

  always_ff @(posedge sys_clk or posedge sys_rst)
    if (sys_rst)                         wd_cnt <= '0;
    else if (hold_q || tog_seen || wd_fire) wd_cnt <= '0;
    else                                 wd_cnt <= wd_cnt + TW'(1);

  always_ff @(posedge sys_clk or posedge sys_rst)
    if (sys_rst) begin
      tog_sync <= '0;
      tog_prev <= 1'b0;
    end else begin
      tog_sync <= {tog_sync[SYNC_STAGES-2:0], tog_loc};
      tog_prev <= tog_sync[SYNC_STAGES-1];
    end

  always_ff @(posedge loc_clk or posedge sys_rst)
    if (sys_rst) tog_loc <= 1'b0;
    else         tog_loc <= ~tog_loc;

  always_ff @(posedge loc_clk or posedge hold_q)
    if (hold_q) rst_pipe <= '1;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b0};

endmodule

module lrst_gen_chk #(
  parameter int HOLD_CYCLES    = 16,
  parameter int SYNC_STAGES    = 3,
  parameter int TIMEOUT_CYCLES = 256
) (
  input logic sys_clk,
  input logic sys_rst,
  input logic loc_clk,
  input logic clkgen_rst,
  input logic reg_rst
);
  logic [15:0] hi_run, lo_run;

  always_ff @(posedge sys_clk or posedge sys_rst)
    if (sys_rst) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= !clkgen_rst ? 16'd0 : (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
      lo_run <=  clkgen_rst ? 16'd0 : (lo_run == 16'hFFFF) ? lo_run : lo_run + 16'd1;
    end

  AST_REG_UNDER_CLKGEN: assert property (@(posedge sys_clk) disable iff (sys_rst)
    clkgen_rst |-> reg_rst); // R3
  AST_HOLD_LENGTH: assert property (@(posedge sys_clk) disable iff (sys_rst)
    $fell(clkgen_rst) |-> (32'(hi_run) >= HOLD_CYCLES)); // R2
  AST_NO_EARLY_TIMEOUT: assert property (@(posedge sys_clk) disable iff (sys_rst)
    ($rose(clkgen_rst) && lo_run != 16'd0) |-> (32'(lo_run) >= TIMEOUT_CYCLES)); // R5
  AST_REG_RELEASE_ORDER: assert property (@(posedge loc_clk) disable iff (sys_rst)
    $fell(reg_rst) |-> !clkgen_rst); // R4
endmodule

bind lrst_gen lrst_gen_chk #(
  .HOLD_CYCLES(HOLD_CYCLES),
  .SYNC_STAGES(SYNC_STAGES),
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
) u_chk (
  .sys_clk(sys_clk),
  .sys_rst(sys_rst),
  .loc_clk(loc_clk),
  .clkgen_rst(clkgen_rst),
  .reg_rst(reg_rst)
);

// File: tb/test_lrst_gen.sv
`timescale 1ns/100ps
module test_lrst_gen;
  localparam int SYS_HALF = 5;
  localparam int HOLD     = 5;
  localparam int SYNC     = 3;
  localparam int TMO      = 12;

  logic sys_clk = 1'b0;
  logic loc_clk = 1'b0;
  logic sys_rst;
  logic clkgen_rst, reg_rst;
  bit   loc_run = 1'b1;
  int   loc_half = 4;
  int   vectors = 0, errors = 0;

  lrst_gen #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC), .TIMEOUT_CYCLES(TMO)) i_lrst_gen (
    .sys_clk(sys_clk), .sys_rst(sys_rst), .loc_clk(loc_clk),
    .clkgen_rst(clkgen_rst), .reg_rst(reg_rst));

  always #SYS_HALF sys_clk = ~sys_clk;
  initial forever begin
    #(loc_half);
    if (loc_run) loc_clk = ~loc_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  task automatic measure_hold(output int n, output int reg_drops);
    n = 0; reg_drops = 0;
    do begin
      @(posedge sys_clk); #1; n++;
      if (clkgen_rst && !reg_rst) reg_drops++;
    end while (clkgen_rst && n < 1000);
  endtask

  task automatic measure_regrel(output int n);
    @(negedge clkgen_rst);
    n = 0;
    do begin
      @(posedge loc_clk); #1; n++;
    end while (reg_rst && n < 1000);
  endtask

  task automatic quiet_window(input string req);
    int bad = 0;
    repeat (200) begin
      @(negedge sys_clk);
      if (clkgen_rst || reg_rst) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    #200000;
    errors++; vectors++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    int nh, nr, drops, n;
    int halves[6] = '{2, 4, 6, 8, 10, 14};
    sys_rst = 1'b1;
    #2;
    check(clkgen_rst == 1'b1, "R1 clkgen at reset", clkgen_rst, 1);
    check(reg_rst == 1'b1, "R1 reg at reset", reg_rst, 1);

    foreach (halves[i]) begin
      loc_half = halves[i];
      @(negedge sys_clk);
      sys_rst = 1'b1;
      #1;
      check(clkgen_rst == 1'b1, "R1 async clkgen", clkgen_rst, 1);
      check(reg_rst == 1'b1, "R1 async reg", reg_rst, 1);
      repeat (3) @(negedge sys_clk);
      sys_rst = 1'b0;
      fork
        measure_hold(nh, drops);
        measure_regrel(nr);
      join
      check(nh == HOLD, "R2 hold after global reset", nh, HOLD);
      check(drops == 0, "R3 reg covers clkgen", drops, 0);
      check(nr == SYNC, "R4 local edges to release", nr, SYNC);
      quiet_window("R6 live clock no timeout");
    end

    loc_half = 4;
    @(negedge sys_clk);
    loc_run = 1'b0;
    n = 0;
    do begin
      @(posedge sys_clk); #1; n++;
    end while (!clkgen_rst && n < 1000);
    check(n >= TMO && n <= TMO + SYNC + 4, "R5 first detection window", n, TMO);
    check(reg_rst == 1'b1, "R3 reg asserted with dead clock", reg_rst, 1);

    for (int k = 0; k < 3; k++) begin
      measure_hold(nh, drops);
      check(nh == HOLD, "R2 hold after timeout", nh, HOLD);
      check(drops == 0, "R3 reg held during hold", drops, 0);
      n = 0; drops = 0;
      do begin
        @(posedge sys_clk); #1; n++;
        if (!reg_rst) drops++;
      end while (!clkgen_rst && n < 1000);
      check(n == TMO, "R5 timeout length", n, TMO);
      check(drops == 0, "R3 reg stays high without local edges", drops, 0);
    end

    loc_run = 1'b1;
    fork
      measure_hold(nh, drops);
      measure_regrel(nr);
    join
    check(nh == HOLD, "R2 hold before revival", nh, HOLD);
    check(nr == SYNC, "R4 release after revival", nr, SYNC);
    quiet_window("R6 revived clock no timeout");

    finish_run();
  end
endmodule